// File: doc/BRIEF.md
# Phase-Staggered Brightness Dimmer

This block takes a pulse-width brightness signal from a host and works out its duty cycle as an 8-bit code. The code is measured by counting clock cycles. It then rebuilds the brightness as a new set of channel enable pulses at a dimming period set by software. In that regenerated mode the channel pulses are staggered in time, so that not all strings switch at the same instant. This evens out the supply current seen by the boost stage. A direct mode skips the regeneration: every enabled channel then copies the incoming signal with no stagger.

The measurement path contains a small state machine with three states. `M_IDLE` waits for a rising edge of the synchronized input that closes a full input period. On such an edge it takes the transition start and goes to `M_DIV`. `M_DIV` runs a bit-serial restoring division of the high time, scaled to the code range, by the period length. When the last quotient bit is produced it takes the transition done and goes to `M_APPLY`. `M_APPLY` compares the quotient with the held code through a hysteresis window, then takes the transition back to `M_IDLE`. Separately from the state machine, a stall detector forces the code to the static input level when edges stop arriving.

In regenerated mode the code that drives the channels is sampled once per dimming period, when the dimming counter wraps. As a result, every period carries exactly one contiguous pulse per channel.

Top module: `phase_dimmer`

## Requirements
- R1: While reset is asserted, every channel enable is 0 and the duty code is 0.
- R2: For an input period of P cycles with H high cycles, the bench computes q = floor(H*4080/P). If |q - 16*code| >= 8, the code becomes floor(q/16). The new code is visible within P plus 40 cycles after the rising edge that closes the period.
- R3: If |q - 16*code| < 8, the code keeps its value, even when floor(q/16) differs from it.
- R4: In regenerated mode, with 0 < code < 255 and a dimming period of D cycles, each enabled channel is high for max(1, floor(code*D/256)) cycles per period. This high time is one contiguous pulse, wrapping across the period end.
- R5: With ch_sel = 0 (two channels), channel 1 rises floor(D/2) cycles after channel 0.
- R6: With ch_sel = 1 (three channels) or ch_sel = 2 or 3 (four channels), channel k rises k*floor(D/4) cycles after channel 0.
- R7: In regenerated mode, an active code of 255 holds all enabled channels high and an active code of 0 holds all channels low.
- R8: If no rising input edge arrives for more than twice the last measured period, the code is forced to 0 when the input is low and to 255 when it is high.
- R9: In direct mode, each enabled channel equals the input level sampled 3 clock edges earlier.
- R10: Only the channels selected by ch_sel can be high (0: channels 0-1, 1: channels 0-2, 2 or 3: channels 0-3). The channels that are not selected stay at 0 in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 1 | Asynchronous brightness pulse input |
| direct_mode | input | 1 | 1: channels copy the input; 0: regenerated and staggered |
| ch_sel | input | 2 | Channel count select (0: two, 1: three, 2/3: four) |
| dim_period | input | PER_W | Dimming period in clock cycles |
| ch_en | output | 4 | Per-channel enables |
| duty_code | output | 8 | Measured duty code |

## Verification
The assertions check four things on every cycle. Unselected channels stay low. Direct mode follows the input with the fixed three-edge latency. An active code of 0 or 255 pins the regenerated outputs. The duty code never changes on two consecutive cycles. Other behaviour can only be shown by the bench scenarios: the arithmetic of the code, the hysteresis hold, the pulse lengths and the phase offsets between channels, and the stall fallback. Each of these depends on a whole input period or dimming period of history.

// File: rtl/dimmer_pkg.sv
package dimmer_pkg;
    localparam int CODE_W = 8;
    localparam int FRAC_W = 4;
    localparam int NUM_CH = 4;

    localparam logic [1:0] SEL_TWO   = 2'd0;
    localparam logic [1:0] SEL_THREE = 2'd1;

    typedef enum logic [1:0] {
        M_IDLE  = 2'd0,
        M_DIV   = 2'd1,
        M_APPLY = 2'd2
    } meter_state_t;
endpackage

// File: rtl/duty_meter.sv
module duty_meter
    import dimmer_pkg::*;
#(
    parameter int MEAS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_s,
    output logic [CODE_W-1:0] code
);
    localparam int SCALE_W = CODE_W + FRAC_W;
    localparam int DW      = MEAS_W + SCALE_W;
    localparam int STEP_W  = $clog2(DW + 1);
    localparam logic [SCALE_W-1:0] SCALE = SCALE_W'(((1 << CODE_W) - 1) << FRAC_W);
    localparam logic [SCALE_W:0]   HALF  = (SCALE_W + 1)'(1 << (FRAC_W - 1));

    meter_state_t        state, nxt;
    logic                prev_s, seen, have_per;
    logic [MEAS_W-1:0]   per_cnt, high_cnt, cap_per, rem;
    logic [DW-1:0]       dvd, quo;
    logic [STEP_W-1:0]   step;
    logic                rise, start, stall, take, div_last, far;
    logic [MEAS_W:0]     rem_sh, rem_sub;
    logic [SCALE_W-1:0]  q_frac;
    logic [SCALE_W:0]    q_ext, held_ext;

    assign rise     = pwm_s & ~prev_s;
    assign start    = rise & seen & (state == M_IDLE);
    assign stall    = have_per && ({1'b0, per_cnt} > {cap_per, 1'b0});
    assign rem_sh   = {rem, dvd[DW-1]};
    assign take     = rem_sh >= {1'b0, cap_per};
    assign rem_sub  = rem_sh - {1'b0, cap_per};
    assign div_last = (step == STEP_W'(DW - 1));
    assign q_frac   = (|quo[DW-1:SCALE_W]) ? {SCALE_W{1'b1}} : quo[SCALE_W-1:0];
    assign q_ext    = {1'b0, q_frac};
    assign held_ext = {1'b0, code, {FRAC_W{1'b0}}};
    assign far      = (q_ext >= held_ext + HALF) || (q_ext + HALF <= held_ext);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= M_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            M_IDLE:  if (start) nxt = M_DIV;
            M_DIV:   if (div_last) nxt = M_APPLY;
            M_APPLY: nxt = M_IDLE;
            default: nxt = M_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_s   <= 1'b0;
            seen     <= 1'b0;
            have_per <= 1'b0;
            per_cnt  <= '0;
            high_cnt <= '0;
            cap_per  <= '0;
            dvd      <= '0;
            rem      <= '0;
            quo      <= '0;
            step     <= '0;
            code     <= '0;
        end else begin
            prev_s <= pwm_s;
            if (rise) begin
                seen     <= 1'b1;
                per_cnt  <= MEAS_W'(1);
                high_cnt <= MEAS_W'(1);
            end else begin
                if (~&per_cnt) per_cnt <= per_cnt + 1'b1;
                if (pwm_s && ~&high_cnt) high_cnt <= high_cnt + 1'b1;
            end
            if (start) begin
                cap_per  <= per_cnt;
                have_per <= 1'b1;
                dvd      <= DW'(high_cnt) * DW'(SCALE);
                rem      <= '0;
                quo      <= '0;
                step     <= '0;
            end else if (state == M_DIV) begin
                dvd  <= {dvd[DW-2:0], 1'b0};
                rem  <= take ? rem_sub[MEAS_W-1:0] : rem_sh[MEAS_W-1:0];
                quo  <= {quo[DW-2:0], take};
                step <= step + 1'b1;
            end
            if (stall)
                code <= {CODE_W{pwm_s}};
            else if (state == M_APPLY && far)
                code <= q_frac[SCALE_W-1:FRAC_W];
        end
    end
endmodule

// File: rtl/phase_gen.sv
module phase_gen
    import dimmer_pkg::*;
#(
    parameter int PER_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PER_W-1:0]  period,
    input  logic [CODE_W-1:0] code,
    input  logic              direct,
    input  logic              pwm_s,
    input  logic [1:0]        ch_sel,
    output logic [NUM_CH-1:0] ch_en,
    output logic [CODE_W-1:0] active_code
);
    localparam int PROD_W = PER_W + CODE_W;

    logic [PER_W-1:0]  pcnt, spacing, raw_len, on_len;
    logic [PROD_W-1:0] prod;
    logic [2:0]        n_act;
    logic              wrap, full, none;
    logic [NUM_CH-1:0] next_en;

    assign wrap    = (period == '0) || (pcnt >= period - PER_W'(1));
    assign spacing = (ch_sel == SEL_TWO) ? (period >> 1) : (period >> 2);
    assign n_act   = (ch_sel == SEL_TWO) ? 3'd2 : (ch_sel == SEL_THREE) ? 3'd3 : 3'd4;
    assign prod    = PROD_W'(active_code) * PROD_W'(period);
    assign raw_len = prod[PROD_W-1:CODE_W];
    assign on_len  = (raw_len == '0) ? PER_W'(1) : raw_len;
    assign full    = &active_code;
    assign none    = (active_code == '0);

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        logic [PER_W+1:0] off_w;
        logic [PER_W-1:0] off;
        logic [PER_W:0]   rel;
        logic             hit, en_k;
        assign off_w = (PER_W + 2)'(k) * {2'b00, spacing};
        assign off   = off_w[PER_W-1:0];
        assign rel   = (pcnt >= off) ? ({1'b0, pcnt} - {1'b0, off})
                                     : ({1'b0, pcnt} + {1'b0, period} - {1'b0, off});
        assign hit   = rel < {1'b0, on_len};
        assign en_k  = (3'(k) < n_act);
        assign next_en[k] = en_k & (direct ? pwm_s : (full | (~none & hit)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt        <= '0;
            active_code <= '0;
            ch_en       <= '0;
        end else begin
            pcnt  <= wrap ? '0 : pcnt + 1'b1;
            if (wrap) active_code <= code;
            ch_en <= next_en;
        end
    end
endmodule

// File: rtl/phase_dimmer.sv
module phase_dimmer
    import dimmer_pkg::*;
#(
    parameter int MEAS_W = 16,
    parameter int PER_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_in,
    input  logic              direct_mode,
    input  logic [1:0]        ch_sel,
    input  logic [PER_W-1:0]  dim_period,
    output logic [NUM_CH-1:0] ch_en,
    output logic [CODE_W-1:0] duty_code
);
    logic              sync_a, sync_b;
    logic [CODE_W-1:0] active_code;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
        end else begin
            sync_a <= pwm_in;
            sync_b <= sync_a;
        end
    end

    duty_meter #(.MEAS_W(MEAS_W)) u_meter (
        .clk   (clk),
        .rst_n (rst_n),
        .pwm_s (sync_b),
        .code  (duty_code)
    );

    phase_gen #(.PER_W(PER_W)) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .period      (dim_period),
        .code        (duty_code),
        .direct      (direct_mode),
        .pwm_s       (sync_b),
        .ch_sel      (ch_sel),
        .ch_en       (ch_en),
        .active_code (active_code)
    );
endmodule

// File: rtl/dimmer_checks.sv
module dimmer_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       pwm_in,
    input logic       direct_mode,
    input logic [1:0] ch_sel,
    input logic [3:0] ch_en,
    input logic [7:0] duty_code,
    input logic [7:0] active_code
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 1'b1;
    end

    p_two_unused_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && $past(ch_sel) == 2'd0) |-> (ch_en[3:2] == 2'b00));

    p_three_unused_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && $past(ch_sel) == 2'd1) |-> (ch_en[3] == 1'b0));

    p_direct_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && $past(direct_mode) && $past(ch_sel) == 2'd2)
        |-> (ch_en == {4{$past(pwm_in, 3)}}));

    p_full_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && $past(active_code) == 8'hFF && !$past(direct_mode)
         && $past(ch_sel) == 2'd2) |-> (ch_en == 4'hF));

    p_zero_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && $past(active_code) == 8'h00 && !$past(direct_mode))
        |-> (ch_en == 4'h0));

    p_code_settles_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && duty_code != $past(duty_code)) |=> $stable(duty_code));
endmodule

bind phase_dimmer dimmer_checks u_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwm_in      (pwm_in),
    .direct_mode (direct_mode),
    .ch_sel      (ch_sel),
    .ch_en       (ch_en),
    .duty_code   (duty_code),
    .active_code (active_code)
);

// File: tb/phase_dimmer_bench.sv
module phase_dimmer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwm_in;
    logic        direct_mode = 1'b0;
    logic [1:0]  ch_sel = 2'd2;
    logic [15:0] dim_period = 16'd200;
    logic [3:0]  ch_en;
    logic [7:0]  duty_code;

    int n_cmp = 0;
    int n_bad = 0;

    // generator controls
    logic g_run = 1'b0;
    logic g_level = 1'b0;
    int   g_h = 1, g_p = 2;

    always #10 clk = ~clk;

    phase_dimmer u_phase_dimmer (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .direct_mode(direct_mode),
        .ch_sel(ch_sel), .dim_period(dim_period), .ch_en(ch_en), .duty_code(duty_code)
    );

    // columns: high, period, dim period, ch_sel, expected code, expected pulse length
    localparam int NV = 7;
    localparam int VT [NV][6] = '{
        '{100, 200, 200, 2, 127, 99},
        '{ 50, 200, 160, 0,  63, 39},
        '{150, 200, 120, 1, 191, 89},
        '{  3, 250, 256, 2,   3,  3},
        '{  3, 261, 256, 2,   3,  3},
        '{  4, 250, 256, 2,   4,  4},
        '{  1, 200, 100, 2,   1,  1}
    };

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    initial begin : gen
        int pos = 0, ph = 1, pp = 2;
        pwm_in = 1'b0;
        forever begin
            @(negedge clk);
            if (!g_run) begin
                pwm_in = g_level;
                pos = 0;
            end else begin
                if (pos == 0) begin ph = g_h; pp = g_p; end
                pwm_in = (pos < ph);
                pos = (pos + 1 >= pp) ? 0 : pos + 1;
            end
        end
    end

    task automatic measure(input int d, input int sel, input int len);
        int cnt[4];
        int rise[4];
        logic [3:0] prev;
        bit found = 0;
        int sp = (sel == 0) ? d / 2 : d / 4;
        int nact = (sel == 0) ? 2 : (sel == 1) ? 3 : 4;
        for (int k = 0; k < 4; k++) begin cnt[k] = 0; rise[k] = -1; end
        prev = ch_en;
        for (int i = 0; i < 2 * d + 20 && !found; i++) begin
            @(negedge clk);
            if (ch_en[0] && !prev[0]) found = 1;
            else prev = ch_en;
        end
        check(found, "R4 channel 0 rise", int'(found), 1);
        for (int i = 0; i < d; i++) begin
            if (i > 0) @(negedge clk);
            for (int k = 0; k < 4; k++) begin
                if (ch_en[k]) cnt[k]++;
                if (ch_en[k] && !prev[k] && rise[k] < 0) rise[k] = i;
            end
            prev = ch_en;
        end
        for (int k = 0; k < 4; k++) begin
            if (k < nact) begin
                check(cnt[k] == len, "R4 pulse length", cnt[k], len);
                if (k > 0)
                    check(rise[k] == k * sp, (sel == 0) ? "R5 offset" : "R6 offset",
                          rise[k], k * sp);
            end else begin
                check(cnt[k] == 0, "R10 unused channel", cnt[k], 0);
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin : main
        bit ok;
        repeat (5) @(negedge clk);
        check(ch_en == 4'h0, "R1 enables in reset", ch_en, 0);
        check(duty_code == 8'h0, "R1 code in reset", duty_code, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(duty_code == 8'h0, "R1 code after reset", duty_code, 0);

        for (int v = 0; v < NV; v++) begin
            g_h = VT[v][0];
            g_p = VT[v][1];
            dim_period = 16'(VT[v][2]);
            ch_sel = 2'(VT[v][3]);
            g_run = 1'b1;
            repeat (4 * VT[v][1] + 2 * VT[v][2] + 100) @(negedge clk);
            check(duty_code == 8'(VT[v][4]), (v == 4) ? "R3 hysteresis hold" : "R2 duty code",
                  duty_code, VT[v][4]);
            measure(VT[v][2], VT[v][3], VT[v][5]);
        end

        // input stuck low: stall forces code to 0, all outputs off
        g_run = 1'b0;
        g_level = 1'b0;
        repeat (800) @(negedge clk);
        check(duty_code == 8'h00, "R8 stall low code", duty_code, 0);
        ok = 1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (ch_en != 4'h0) ok = 0;
        end
        check(ok, "R7 zero code all off", int'(ok), 1);

        // input stuck high: stall forces code to 255, all outputs on
        g_level = 1'b1;
        repeat (3000) @(negedge clk);
        check(duty_code == 8'hFF, "R8 stall high code", duty_code, 255);
        ok = 1;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (ch_en != 4'hF) ok = 0;
        end
        check(ok, "R7 full code all on", int'(ok), 1);
        ch_sel = 2'd1;
        repeat (3) @(negedge clk);
        check(ch_en == 4'b0111, "R10 three channels full", ch_en, 7);

        // direct mode
        direct_mode = 1'b1;
        ch_sel = 2'd2;
        g_level = 1'b0;
        repeat (6) @(negedge clk);
        check(ch_en == 4'h0, "R9 direct low", ch_en, 0);
        g_level = 1'b1;
        repeat (6) @(negedge clk);
        check(ch_en == 4'hF, "R9 direct high", ch_en, 15);
        ch_sel = 2'd0;
        repeat (3) @(negedge clk);
        check(ch_en == 4'b0011, "R10 direct two channels", ch_en, 3);

        // reset during operation
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(ch_en == 4'h0, "R1 enables on reset", ch_en, 0);
        check(duty_code == 8'h0, "R1 code on reset", duty_code, 0);

        summary();
        $finish;
    end
endmodule